// File: doc/BRIEF.md
# Parity-Protected Parallel 4-Point FFT Array

This block runs four identical 4-point discrete Fourier transforms side by side. Each works on its own complex input vector, and all four complete in the same cycle. A fifth, redundant transform is fed with the point-by-point sum of the four input vectors. Because the transform is linear, the output of this fifth transform equals the sum of the four data outputs. That relation lets the block rebuild any single lane: take the parity output and subtract the other three lanes.

To find a faulty lane, each data lane has an energy check. The check compares four times the input energy with the output energy, which are equal for an exact 4-point transform. A lane is flagged when the two differ by more than a programmable margin. If exactly one lane is flagged, that lane's outputs are replaced by the rebuilt values. If two or more lanes are flagged, the outputs pass through unchanged and a sticky flag marks the transform as uncorrectable.

The logic that forms the parity input, the energy checks and the rebuild arithmetic is each built three times, and a majority vote picks the result. A test port XORs a mask into the real part of bin 0 of any chosen unit, including the parity unit, so that the correction paths can be exercised.

Top module: `parfft_guard`

## Requirements
- R1: One cycle after an `in_valid` cycle, `out_valid` is high for one cycle. Each lane's output is X[k] = sum over n of x[n]·(-j)^(n·k), with each component IW+2 bits wide. Point n of lane u sits at bits [(u·4+n)·W +: W] of each flat bus, where W is IW for inputs and IW+2 for outputs.
- R2: While `in_valid` is low, `out_valid` reads 0 in the next cycle, and `dout_re`, `dout_im`, `err_flag` and `uncorr` keep their values.
- R3: `err_flag[u]` is 1 exactly when |4·Σ|x|² − Σ|Y|²| > `chk_thresh` for lane u. Here Y is that lane's transform output after any injected fault. With no fault injected, every flag is 0.
- R4: When exactly one lane is flagged, that lane's outputs equal the parity output minus the sum of the other three lanes' outputs, reduced to IW+2 bits. This yields the fault-free transform.
- R5: When two or more lanes are flagged in one transform, all outputs are the unit outputs as computed (faults included), and `uncorr` is set.
- R6: `uncorr` stays set until reset.
- R7: A fault injected only into the parity unit leaves every data output and flag equal to the fault-free result.
- R8: A lane is not flagged when its energy difference equals `chk_thresh`. It is flagged when the difference exceeds `chk_thresh` by one.
- R9: `fault_sel[u]` for u in 0..3 selects data lane u, and `fault_sel[4]` selects the parity unit. For each selected unit, `fault_xor` is XORed into the real part of bin 0 of its output. With the margin set to maximum, the altered value appears at the data output.
- R10: After reset, `out_valid`, `err_flag`, `uncorr`, `dout_re` and `dout_im` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vectors are valid this cycle |
| din_re | input | NFFT·4·IW | Real parts of all lane inputs, flat |
| din_im | input | NFFT·4·IW | Imaginary parts of all lane inputs, flat |
| chk_thresh | input | EW | Energy-check margin |
| fault_sel | input | NFFT+1 | Units receiving an injected fault (bit NFFT is parity) |
| fault_xor | input | IW+2 | Mask XORed into bin 0 real of selected units |
| out_valid | output | 1 | Output vectors updated this cycle |
| dout_re | output | NFFT·4·(IW+2) | Corrected real outputs, flat |
| dout_im | output | NFFT·4·(IW+2) | Corrected imaginary outputs, flat |
| err_flag | output | NFFT | Per-lane energy-check result |
| uncorr | output | 1 | Sticky: two or more lanes flagged at once |

## Verification
The assertions check on every cycle:
- the one-cycle valid latency and the hold of outputs while idle;
- the stickiness of `uncorr`, and that it only rises on a multi-lane flag;
- that a single flag produces exactly one flagged lane;
- that a parity-only fault with no data flag leaves the outputs equal to the raw lane transforms.

Only the bench scenarios can show:
- that the numbers are correct: the transform values, the rebuilt lane, and the exact boundary where a flag appears as the margin moves across the energy difference;
- that a reset clears the sticky flag.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    localparam int NPT   = 4;
    localparam int NCOPY = 3;
endpackage

// File: rtl/fft4_unit.sv
module fft4_unit import pfa_pkg::*; #(
    parameter int IW = 8,
    parameter int OW = IW + 2
) (
    input  logic signed [IW-1:0] x_re [NPT],
    input  logic signed [IW-1:0] x_im [NPT],
    output logic signed [OW-1:0] y_re [NPT],
    output logic signed [OW-1:0] y_im [NPT]
);
    logic signed [OW-1:0] er [NPT];
    logic signed [OW-1:0] ei [NPT];
    logic signed [OW-1:0] s0r, s0i, d0r, d0i, s1r, s1i, d1r, d1i;

    always_comb begin
        for (int n = 0; n < NPT; n++) begin
            er[n] = OW'(x_re[n]);
            ei[n] = OW'(x_im[n]);
        end
    end

    // first butterfly stage: even pair and odd pair
    assign s0r = er[0] + er[2];
    assign s0i = ei[0] + ei[2];
    assign d0r = er[0] - er[2];
    assign d0i = ei[0] - ei[2];
    assign s1r = er[1] + er[3];
    assign s1i = ei[1] + ei[3];
    assign d1r = er[1] - er[3];
    assign d1i = ei[1] - ei[3];

    // second stage: twiddles are +-1 and +-j only
    assign y_re[0] = s0r + s1r;
    assign y_im[0] = s0i + s1i;
    assign y_re[2] = s0r - s1r;
    assign y_im[2] = s0i - s1i;
    assign y_re[1] = d0r + d1i;
    assign y_im[1] = d0i - d1r;
    assign y_re[3] = d0r - d1i;
    assign y_im[3] = d0i + d1r;
endmodule

// File: rtl/parseval_chk.sv
module parseval_chk import pfa_pkg::*; #(
    parameter int IW = 8,
    parameter int OW = IW + 2,
    parameter int EW = 2 * OW + 4
) (
    input  logic signed [IW-1:0] x_re [NPT],
    input  logic signed [IW-1:0] x_im [NPT],
    input  logic signed [OW-1:0] y_re [NPT],
    input  logic signed [OW-1:0] y_im [NPT],
    input  logic        [EW-1:0] thr,
    output logic                 flag
);
    logic signed [EW:0] ein, eout, dif;
    logic        [EW:0] mag;

    function automatic logic signed [EW:0] sq(input logic signed [EW:0] v);
        return v * v;
    endfunction

    always_comb begin
        ein  = '0;
        eout = '0;
        for (int n = 0; n < NPT; n++) begin
            ein  = ein  + sq((EW+1)'(x_re[n])) + sq((EW+1)'(x_im[n]));
            eout = eout + sq((EW+1)'(y_re[n])) + sq((EW+1)'(y_im[n]));
        end
        dif = (ein <<< 2) - eout;
        mag = dif[EW] ? unsigned'(-dif) : unsigned'(dif);
    end

    assign flag = mag > {1'b0, thr};
endmodule

// File: rtl/maj3.sv
module maj3 #(
    parameter int WIDTH = 1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] y
);
    assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/parfft_guard.sv
module parfft_guard import pfa_pkg::*; #(
    parameter  int NFFT = 4,
    parameter  int IW   = 8,
    localparam int OW   = IW + 2,
    localparam int GW   = $clog2(NFFT),
    localparam int SW   = IW + GW,
    localparam int PW   = SW + 2,
    localparam int EW   = 2 * OW + 4,
    localparam int XW   = NFFT * NPT * IW,
    localparam int DW   = NFFT * NPT * OW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XW-1:0]   din_re,
    input  logic [XW-1:0]   din_im,
    input  logic [EW-1:0]   chk_thresh,
    input  logic [NFFT:0]   fault_sel,
    input  logic [OW-1:0]   fault_xor,
    output logic            out_valid,
    output logic [DW-1:0]   dout_re,
    output logic [DW-1:0]   dout_im,
    output logic [NFFT-1:0] err_flag,
    output logic            uncorr
);
    typedef struct packed {
        logic            vld;
        logic            uncorr;
        logic [NFFT-1:0] flag;
        logic [DW-1:0]   re;
        logic [DW-1:0]   im;
    } state_t;

    state_t st_d, st_q;

    logic signed [IW-1:0] xr     [NFFT][NPT];
    logic signed [IW-1:0] xi     [NFFT][NPT];
    logic signed [OW-1:0] yr_raw [NFFT][NPT];
    logic signed [OW-1:0] yi_raw [NFFT][NPT];
    logic signed [OW-1:0] yr     [NFFT][NPT];
    logic signed [OW-1:0] yi     [NFFT][NPT];
    logic [DW-1:0]        yr_flat, yi_flat;
    logic [NFFT-1:0]      flag_v;

    // sum of all lanes per point, one copy of the adder tree
    function automatic logic [NPT*SW-1:0] lane_sum(input logic [XW-1:0] d);
        logic signed [SW-1:0] acc;
        lane_sum = '0;
        for (int n = 0; n < NPT; n++) begin
            acc = '0;
            for (int u = 0; u < NFFT; u++) begin
                acc = acc + SW'($signed(d[(u*NPT+n)*IW +: IW]));
            end
            lane_sum[n*SW +: SW] = acc;
        end
    endfunction

    // every lane rebuilt as parity minus the other lanes
    function automatic logic [DW-1:0] rebuild(input logic [DW-1:0] y,
                                              input logic [NPT*PW-1:0] p);
        logic signed [PW-1:0] tot, v;
        rebuild = '0;
        for (int n = 0; n < NPT; n++) begin
            tot = '0;
            for (int u = 0; u < NFFT; u++) begin
                tot = tot + PW'($signed(y[(u*NPT+n)*OW +: OW]));
            end
            for (int u = 0; u < NFFT; u++) begin
                v = $signed(p[n*PW +: PW])
                    - (tot - PW'($signed(y[(u*NPT+n)*OW +: OW])));
                rebuild[(u*NPT+n)*OW +: OW] = v[OW-1:0];
            end
        end
    endfunction

    // ---------------- data lanes with voted energy checks ----------------
    for (genvar u = 0; u < NFFT; u++) begin : g_lane
        logic [NCOPY-1:0] flag_c;

        for (genvar n = 0; n < NPT; n++) begin : g_pt
            assign xr[u][n] = din_re[(u*NPT+n)*IW +: IW];
            assign xi[u][n] = din_im[(u*NPT+n)*IW +: IW];
            assign yr[u][n] = (n == 0 && fault_sel[u]) ? (yr_raw[u][n] ^ fault_xor)
                                                       : yr_raw[u][n];
            assign yi[u][n] = yi_raw[u][n];
            assign yr_flat[(u*NPT+n)*OW +: OW] = yr[u][n];
            assign yi_flat[(u*NPT+n)*OW +: OW] = yi[u][n];
        end

        fft4_unit #(.IW(IW), .OW(OW)) u_fft (
            .x_re (xr[u]),
            .x_im (xi[u]),
            .y_re (yr_raw[u]),
            .y_im (yi_raw[u])
        );

        for (genvar t = 0; t < NCOPY; t++) begin : g_chk
            parseval_chk #(.IW(IW), .OW(OW), .EW(EW)) u_chk (
                .x_re (xr[u]),
                .x_im (xi[u]),
                .y_re (yr[u]),
                .y_im (yi[u]),
                .thr  (chk_thresh),
                .flag (flag_c[t])
            );
        end

        maj3 #(.WIDTH(1)) u_vote_flag (
            .a (flag_c[0]),
            .b (flag_c[1]),
            .c (flag_c[2]),
            .y (flag_v[u])
        );
    end

    // ---------------- parity path ----------------
    logic [NCOPY-1:0][NPT*SW-1:0] psum_re_c, psum_im_c;
    logic [NPT*SW-1:0]            psum_re, psum_im;
    logic signed [SW-1:0]         pxr [NPT];
    logic signed [SW-1:0]         pxi [NPT];
    logic signed [PW-1:0]         pyr_raw [NPT];
    logic signed [PW-1:0]         pyi_raw [NPT];
    logic [NPT*PW-1:0]            pyr_flat, pyi_flat;

    for (genvar t = 0; t < NCOPY; t++) begin : g_padd
        assign psum_re_c[t] = lane_sum(din_re);
        assign psum_im_c[t] = lane_sum(din_im);
    end

    maj3 #(.WIDTH(NPT*SW)) u_vote_pre (
        .a (psum_re_c[0]), .b (psum_re_c[1]), .c (psum_re_c[2]), .y (psum_re)
    );
    maj3 #(.WIDTH(NPT*SW)) u_vote_pim (
        .a (psum_im_c[0]), .b (psum_im_c[1]), .c (psum_im_c[2]), .y (psum_im)
    );

    for (genvar n = 0; n < NPT; n++) begin : g_ppt
        assign pxr[n] = psum_re[n*SW +: SW];
        assign pxi[n] = psum_im[n*SW +: SW];
        assign pyr_flat[n*PW +: PW] = (n == 0 && fault_sel[NFFT])
                                      ? (pyr_raw[n] ^ PW'(fault_xor)) : pyr_raw[n];
        assign pyi_flat[n*PW +: PW] = pyi_raw[n];
    end

    fft4_unit #(.IW(SW), .OW(PW)) u_par_fft (
        .x_re (pxr),
        .x_im (pxi),
        .y_re (pyr_raw),
        .y_im (pyi_raw)
    );

    // ---------------- voted rebuild ----------------
    logic [NCOPY-1:0][DW-1:0] rb_re_c, rb_im_c;
    logic [DW-1:0]            rb_re, rb_im;

    for (genvar t = 0; t < NCOPY; t++) begin : g_rb
        assign rb_re_c[t] = rebuild(yr_flat, pyr_flat);
        assign rb_im_c[t] = rebuild(yi_flat, pyi_flat);
    end

    maj3 #(.WIDTH(DW)) u_vote_rre (
        .a (rb_re_c[0]), .b (rb_re_c[1]), .c (rb_re_c[2]), .y (rb_re)
    );
    maj3 #(.WIDTH(DW)) u_vote_rim (
        .a (rb_im_c[0]), .b (rb_im_c[1]), .c (rb_im_c[2]), .y (rb_im)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.flag = flag_v;
            st_d.re   = yr_flat;
            st_d.im   = yi_flat;
            if ($countones(flag_v) == 1) begin
                for (int u = 0; u < NFFT; u++) begin
                    if (flag_v[u]) begin
                        st_d.re[u*NPT*OW +: NPT*OW] = rb_re[u*NPT*OW +: NPT*OW];
                        st_d.im[u*NPT*OW +: NPT*OW] = rb_im[u*NPT*OW +: NPT*OW];
                    end
                end
            end
            if ($countones(flag_v) > 1) begin
                st_d.uncorr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign dout_re   = st_q.re;
    assign dout_im   = st_q.im;
    assign err_flag  = st_q.flag;
    assign uncorr    = st_q.uncorr;

    // ---------------- assertions ----------------
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dout_re) && $stable(dout_im)
                       && $stable(err_flag)));

    p_single_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(flag_v) == 1) |=> (out_valid && $onehot(err_flag)));

    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uncorr) |-> ($countones(err_flag) > 1));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr |=> uncorr);

    p_parity_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fault_sel[NFFT] && flag_v == '0)
        |=> (dout_re == $past(yr_flat) && dout_im == $past(yi_flat)));
endmodule

// File: tb/parfft_guard_bench.sv
module parfft_guard_bench;
    import pfa_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NFFT = 4;
    localparam int IW   = 8;
    localparam int OW   = IW + 2;
    localparam int SW   = IW + 2;
    localparam int PW   = SW + 2;
    localparam int EW   = 2 * OW + 4;
    localparam int XW   = NFFT * NPT * IW;
    localparam int DW   = NFFT * NPT * OW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XW-1:0]   din_re = '0;
    logic [XW-1:0]   din_im = '0;
    logic [EW-1:0]   chk_thresh = '0;
    logic [NFFT:0]   fault_sel = '0;
    logic [OW-1:0]   fault_xor = '0;
    logic            out_valid;
    logic [DW-1:0]   dout_re, dout_im;
    logic [NFFT-1:0] err_flag;
    logic            uncorr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int xin_re [NFFT][NPT];
    int xin_im [NFFT][NPT];
    int exp_re [NFFT][NPT];
    int exp_im [NFFT][NPT];
    int last_diff [NFFT];
    logic [NFFT-1:0] exp_flag = '0;
    bit exp_unc = 1'b0;

    parfft_guard #(.NFFT(NFFT), .IW(IW)) u_parfft_guard (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .din_re (din_re), .din_im (din_im), .chk_thresh (chk_thresh),
        .fault_sel (fault_sel), .fault_xor (fault_xor),
        .out_valid (out_valid), .dout_re (dout_re), .dout_im (dout_im),
        .err_flag (err_flag), .uncorr (uncorr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sx(input int v, input int w);
        int m;
        m = v & ((1 << w) - 1);
        if (m[w-1]) m = m - (1 << w);
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic dft4(input int ar[NPT], input int ai[NPT],
                        output int br[NPT], output int bi[NPT]);
        for (int k = 0; k < NPT; k++) begin
            br[k] = 0;
            bi[k] = 0;
            for (int n = 0; n < NPT; n++) begin
                case ((n * k) % 4)
                    0: begin br[k] += ar[n]; bi[k] += ai[n]; end
                    1: begin br[k] += ai[n]; bi[k] -= ar[n]; end
                    2: begin br[k] -= ar[n]; bi[k] -= ai[n]; end
                    default: begin br[k] -= ai[n]; bi[k] += ar[n]; end
                endcase
            end
        end
    endtask

    // independent model of the whole array for the current xin
    task automatic model(input int thr, input logic [NFFT:0] fsel, input int fxor);
        int ar[NPT], ai[NPT], tr[NPT], ti[NPT];
        int yr[NFFT][NPT], yi[NFFT][NPT];
        int pr[NPT], pi[NPT];
        int ein, eout, dd, nfl, accr, acci;
        for (int u = 0; u < NFFT; u++) begin
            for (int n = 0; n < NPT; n++) begin ar[n] = xin_re[u][n]; ai[n] = xin_im[u][n]; end
            dft4(ar, ai, tr, ti);
            for (int n = 0; n < NPT; n++) begin yr[u][n] = tr[n]; yi[u][n] = ti[n]; end
            if (fsel[u]) yr[u][0] = sx(yr[u][0] ^ fxor, OW);
        end
        for (int n = 0; n < NPT; n++) begin
            ar[n] = 0; ai[n] = 0;
            for (int u = 0; u < NFFT; u++) begin ar[n] += xin_re[u][n]; ai[n] += xin_im[u][n]; end
        end
        dft4(ar, ai, pr, pi);
        if (fsel[NFFT]) pr[0] = sx(pr[0] ^ fxor, PW);
        nfl = 0;
        for (int u = 0; u < NFFT; u++) begin
            ein = 0; eout = 0;
            for (int n = 0; n < NPT; n++) begin
                ein  += xin_re[u][n] * xin_re[u][n] + xin_im[u][n] * xin_im[u][n];
                eout += yr[u][n] * yr[u][n] + yi[u][n] * yi[u][n];
            end
            dd = 4 * ein - eout;
            if (dd < 0) dd = -dd;
            last_diff[u] = dd;
            exp_flag[u] = (dd > thr);
            if (exp_flag[u]) nfl++;
        end
        for (int u = 0; u < NFFT; u++) begin
            for (int n = 0; n < NPT; n++) begin exp_re[u][n] = yr[u][n]; exp_im[u][n] = yi[u][n]; end
        end
        if (nfl == 1) begin
            for (int u = 0; u < NFFT; u++) begin
                if (exp_flag[u]) begin
                    for (int n = 0; n < NPT; n++) begin
                        accr = pr[n]; acci = pi[n];
                        for (int j = 0; j < NFFT; j++) begin
                            if (j != u) begin accr -= yr[j][n]; acci -= yi[j][n]; end
                        end
                        exp_re[u][n] = sx(accr, OW);
                        exp_im[u][n] = sx(acci, OW);
                    end
                end
            end
        end
        if (nfl > 1) exp_unc = 1'b1;
    endtask

    task automatic pack_inputs();
        for (int u = 0; u < NFFT; u++) begin
            for (int n = 0; n < NPT; n++) begin
                din_re[(u*NPT+n)*IW +: IW] = IW'(xin_re[u][n]);
                din_im[(u*NPT+n)*IW +: IW] = IW'(xin_im[u][n]);
            end
        end
    endtask

    task automatic rand_inputs();
        for (int u = 0; u < NFFT; u++) begin
            for (int n = 0; n < NPT; n++) begin
                xin_re[u][n] = int'($urandom_range(0, 255)) - 128;
                xin_im[u][n] = int'($urandom_range(0, 255)) - 128;
            end
        end
    endtask

    task automatic compare_outputs(input string req);
        bit ok;
        int act, expv;
        ok = 1'b1; act = 0; expv = 0;
        for (int u = 0; u < NFFT; u++) begin
            for (int n = 0; n < NPT; n++) begin
                if (ok && sx(int'(dout_re[(u*NPT+n)*OW +: OW]), OW) != exp_re[u][n]) begin
                    ok = 1'b0; act = sx(int'(dout_re[(u*NPT+n)*OW +: OW]), OW); expv = exp_re[u][n];
                end
                if (ok && sx(int'(dout_im[(u*NPT+n)*OW +: OW]), OW) != exp_im[u][n]) begin
                    ok = 1'b0; act = sx(int'(dout_im[(u*NPT+n)*OW +: OW]), OW); expv = exp_im[u][n];
                end
            end
        end
        chk(ok, req, act, expv);
    endtask

    // one transform: drive at a falling edge, check one cycle later
    task automatic send(input int thr, input logic [NFFT:0] fsel, input int fxor, input string req);
        pack_inputs();
        chk_thresh = EW'(thr);
        fault_sel  = fsel;
        fault_xor  = OW'(fxor);
        in_valid   = 1'b1;
        model(thr, fsel, fxor);
        @(negedge clk);
        in_valid  = 1'b0;
        fault_sel = '0;
        chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
        compare_outputs(req);
        chk(err_flag == exp_flag, "R3", int'(err_flag), int'(exp_flag));
        chk(uncorr == exp_unc, "R6", int'(uncorr), int'(exp_unc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NFFT:0] fs;
        int d, r, a, b;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0 && err_flag == '0 && uncorr == 1'b0, "R10",
            int'(out_valid) + int'(err_flag) + int'(uncorr), 0);
        chk(dout_re == '0 && dout_im == '0, "R10", int'(|{dout_re, dout_im}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all zero, then extremes
        for (int u = 0; u < NFFT; u++)
            for (int n = 0; n < NPT; n++) begin xin_re[u][n] = 0; xin_im[u][n] = 0; end
        send(0, '0, 0, "R1");
        for (int u = 0; u < NFFT; u++)
            for (int n = 0; n < NPT; n++) begin
                xin_re[u][n] = (u % 2 == 0) ? -128 : 127;
                xin_im[u][n] = (n % 2 == 0) ? 127 : -128;
            end
        send(0, '0, 0, "R1");

        // R2: idle cycle with changed inputs leaves outputs alone
        rand_inputs();
        pack_inputs();
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        compare_outputs("R2");
        chk(err_flag == exp_flag, "R2", int'(err_flag), int'(exp_flag));

        // R4: single data-lane fault rebuilt
        rand_inputs();
        fs = '0; fs[2] = 1'b1;
        send(0, fs, 'h155, "R4");
        chk(err_flag == 4'b0100, "R4", int'(err_flag), 4);

        // R9 / R8: fault visible at max margin, then margin boundary
        rand_inputs();
        fs = '0; fs[1] = 1'b1;
        send((1 << EW) - 1, fs, 'h0a3, "R9");
        model((1 << EW) - 1, fs, 'h0a3);
        d = last_diff[1];
        send(d, fs, 'h0a3, "R8");
        chk(err_flag[1] == 1'b0, "R8", int'(err_flag[1]), 0);
        if (d > 0) begin
            send(d - 1, fs, 'h0a3, "R8");
            chk(err_flag[1] == 1'b1, "R8", int'(err_flag[1]), 1);
        end

        // R7: parity-only fault
        rand_inputs();
        fs = '0; fs[NFFT] = 1'b1;
        send(0, fs, 'h3ff, "R7");
        chk(err_flag == '0, "R7", int'(err_flag), 0);

        // R5: two faulty lanes, then R6 stickiness
        rand_inputs();
        fs = '0; fs[0] = 1'b1; fs[3] = 1'b1;
        send(0, fs, 'h2c1, "R5");
        chk(uncorr == 1'b1, "R5", int'(uncorr), 1);
        rand_inputs();
        send(0, '0, 0, "R6");
        chk(uncorr == 1'b1, "R6", int'(uncorr), 1);

        // R6: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        exp_unc = 1'b0;
        chk(uncorr == 1'b0, "R6", int'(uncorr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            rand_inputs();
            r = int'($urandom_range(0, 99));
            fs = '0;
            if (r < 25) fs[$urandom_range(0, NFFT-1)] = 1'b1;
            else if (r < 35) fs[NFFT] = 1'b1;
            else if (r < 40) begin
                a = int'($urandom_range(0, NFFT-1));
                b = (a + 1 + int'($urandom_range(0, NFFT-2))) % NFFT;
                fs[a] = 1'b1;
                fs[b] = 1'b1;
            end
            send(($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2000)) : 0,
                 fs, int'($urandom_range(1, (1 << OW) - 1)), "R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule